// File: doc/BRIEF.md
# Receive FIFO Timeout Detector

This block sits beside a serial receiver and flags received words that have been left unread for too long. It holds a small receive FIFO, filled through a push port from the shift logic and emptied by software reading a data register. An idle counter runs on the bus clock whenever the FIFO holds data. Every push and every pop sends it back to zero, and it stands still while the FIFO is empty. When it reaches a programmable 16-bit threshold, a sticky timeout flag is raised. That flag, gated by an enable bit, drives an interrupt output.

All settings and status sit behind a simple synchronous register port with four word addresses. A read strobe returns its data on `reg_rdata` one clock later, and a read of the data address pops the FIFO. A threshold of zero switches the timeout function off.

Top module: `rx_idle_watch`

## Requirements
- R1: After reset the threshold and control registers read 0, the status register reads 0x4 (FIFO empty only), and `irq` is 0.
- R2: The threshold sits in bits [15:0] of address 3 and is writable. Bits [31:16] are reserved and read as 0. A read strobe at any address returns its value on `reg_rdata` in the next cycle.
- R3: A word accepted on the push port restarts the idle counter at zero. With threshold T and no later push or pop, the timeout flag and `irq` (when enabled) rise T clock edges after the push edge.
- R4: A pop, which is a read of address 0 while the FIFO holds data, restarts the idle counter at zero. The timeout is then measured from the pop edge.
- R5: The counter advances by one per clock only while the FIFO holds data. While the FIFO is empty it is frozen, and no timeout can occur.
- R6: Once the counter reaches the threshold it stays there until the next push or pop. A cleared flag is therefore not raised again while the data stays untouched.
- R7: With the threshold at zero the flag is never set and the counter is held at zero. Writing a non-zero T starts a timeout T edges after the write edge.
- R8: `irq` is 1 exactly when the timeout flag is set and the enable bit (address 2, bit 0) is 1. It follows changes of either in the same cycle they register.
- R9: The timeout flag is status bit 0. It is cleared only by writing 1 to that bit at address 1, and a clear on the same edge as a new timeout leaves it set.
- R10: The FIFO holds 8 words and returns them in push order through address 0, zero-extended to 32 bits. Status bit 3 reports full and bit 2 reports empty.
- R11: A push while the FIFO is full is dropped and sets the sticky overrun bit, status bit 1. That bit is cleared by writing 1 to it.
- R12: A read of address 0 while the FIFO is empty returns 0 and changes neither the FIFO nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Received word is offered to the FIFO |
| push_data | input | 8 | Received word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address: 0 data, 1 status, 2 control, 3 threshold |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Timeout interrupt |

## Verification
The hardest situation to reach is a write-one-to-clear of the flag landing on the very edge where the counter reaches the threshold. The bench gets there by counting edges from a single push and issuing the status write so that it registers on edge T. It then clears the flag a second time and waits well past the threshold, which shows the saturated counter does not raise the flag again. Restart by pop is timed the same way: the bench picks a pop edge that falls before the first timeout would have fired, so a counter that ignored the pop would trip early.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADR_DATA = 2'd0;
  localparam logic [REG_AW-1:0] ADR_STAT = 2'd1;
  localparam logic [REG_AW-1:0] ADR_CTRL = 2'd2;
  localparam logic [REG_AW-1:0] ADR_THR  = 2'd3;
  localparam int ST_TOUT  = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_FULL  = 3;
endpackage

// File: rtl/rxw_fifo.sv
module rxw_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              empty,
  output logic              full,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign pop_data = mem[rp];

  // storage without reset so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + AW'(1);
      if (pop_ok)  rp <= rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [THR_W-1:0] thr,
  input  logic             restart,
  input  logic             empty,
  output logic [THR_W-1:0] cnt,
  output logic             hit
);
  logic enabled;
  logic below;

  assign enabled = (thr != '0);
  assign below   = (cnt < thr);
  // pulse on the step that lands the counter on the threshold
  assign hit = enabled && !restart && !empty && below &&
               ((cnt + THR_W'(1)) == thr);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (!enabled)        cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (empty || !below) cnt <= cnt;
    else                      cnt <= cnt + THR_W'(1);
  end
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int THR_W  = 16,
  parameter int BUS_W  = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              irq
);
  import rxw_pkg::*;

  logic              pop_req, push_ok, pop_ok, empty, full;
  logic [DATA_W-1:0] pop_data;
  logic [LVL_W-1:0]  level;
  logic [THR_W-1:0]  thr_q, cnt;
  logic              hit, tout_q, ovr_q, ie_q;
  logic              tout_d, ovr_d, ie_d;
  logic              stat_we, ctrl_we, thr_we;

  assign pop_req = reg_rd && (reg_addr == ADR_DATA);
  assign stat_we = reg_wr && (reg_addr == ADR_STAT);
  assign ctrl_we = reg_wr && (reg_addr == ADR_CTRL);
  assign thr_we  = reg_wr && (reg_addr == ADR_THR);

  rxw_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push_valid), .push_data(push_data),
    .pop(pop_req), .pop_data(pop_data),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .empty(empty), .full(full), .level(level)
  );

  rxw_idle_timer #(.THR_W(THR_W)) u_timer (
    .clk(clk), .rst(rst), .thr(thr_q),
    .restart(push_ok || pop_ok), .empty(empty),
    .cnt(cnt), .hit(hit)
  );

  always_comb begin
    tout_d = (tout_q && !(stat_we && reg_wdata[ST_TOUT])) || hit;
    ovr_d  = (ovr_q  && !(stat_we && reg_wdata[ST_OVR]))  || (push_valid && !push_ok);
    ie_d   = ctrl_we ? reg_wdata[0] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tout_q <= 1'b0;
      ovr_q  <= 1'b0;
      ie_q   <= 1'b0;
      thr_q  <= '0;
      irq    <= 1'b0;
    end else begin
      tout_q <= tout_d;
      ovr_q  <= ovr_d;
      ie_q   <= ie_d;
      irq    <= tout_d && ie_d;
      if (thr_we) thr_q <= reg_wdata[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        ADR_DATA: reg_rdata <= empty ? '0 : BUS_W'(pop_data);
        ADR_STAT: begin
          reg_rdata[ST_TOUT]  <= tout_q;
          reg_rdata[ST_OVR]   <= ovr_q;
          reg_rdata[ST_EMPTY] <= empty;
          reg_rdata[ST_FULL]  <= full;
        end
        ADR_CTRL: reg_rdata[0] <= ie_q;
        default:  reg_rdata <= BUS_W'(thr_q);
      endcase
    end
  end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int THR_W = 16,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             push_valid,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             empty,
  input logic             full,
  input logic [LVL_W-1:0] level,
  input logic [THR_W-1:0] thr_q,
  input logic [THR_W-1:0] cnt,
  input logic             thr_we,
  input logic             stat_we,
  input logic [31:0]      reg_wdata,
  input logic             tout_q,
  input logic             ovr_q,
  input logic             ie_q,
  input logic             irq
);
  AST_PUSH_RESTART: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> (cnt == '0)); // R3
  AST_POP_RESTART: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> (cnt == '0)); // R4
  AST_EMPTY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (empty && !push_valid && !thr_we) |=> $stable(cnt)); // R5
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    ((thr_q != '0) && (cnt == thr_q) && !push_ok && !pop_ok && !thr_we) |=> (cnt == $past(cnt))); // R6
  AST_ZERO_THR_SILENT: assert property (@(posedge clk) disable iff (rst)
    ((thr_q == '0) && !tout_q) |=> !tout_q); // R7
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq == (tout_q && ie_q)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tout_q && !(stat_we && reg_wdata[0])) |=> tout_q); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH)); // R10
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push_valid) |=> ovr_q); // R11
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (empty && !push_valid) |=> empty); // R12
endmodule

bind rx_idle_watch rxw_checker #(.THR_W(THR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .push_ok(push_ok),
  .pop_ok(pop_ok), .empty(empty), .full(full), .level(level),
  .thr_q(thr_q), .cnt(cnt), .thr_we(thr_we), .stat_we(stat_we),
  .reg_wdata(reg_wdata), .tout_q(tout_q), .ovr_q(ovr_q), .ie_q(ie_q),
  .irq(irq)
);

// File: tb/tb_rx_idle_watch.sv
module tb_rx_idle_watch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [7:0]  push_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_CTRL = 2'd2, A_THR = 2'd3;

  rx_idle_watch dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic push(input logic [7:0] d);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    logic [31:0] v;
    for (int i = 0; i < 9; i++) rd(A_DATA, v);
    wr(A_STAT, 32'h3);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_THR, v);  chk("R1 threshold", v, 32'd0);
    rd(A_CTRL, v); chk("R1 control", v, 32'd0);
    rd(A_STAT, v); chk("R1 status", v, 32'h4);
  endtask

  task automatic t_thr_reg();
    logic [31:0] v;
    wr(A_THR, 32'hFFFF_ABCD);
    rd(A_THR, v); chk("R2 reserved bits", v, 32'h0000_ABCD);
    wr(A_THR, 32'h0);
  endtask

  task automatic t_push_timing();
    logic [31:0] v;
    wr(A_THR, 32'd5); wr(A_CTRL, 32'd1);
    push(8'h5A);
    idle(4); chk("R3 irq before T", {31'd0, irq}, 32'd0);
    idle(1); chk("R3 irq at T", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); chk("R3 status flag", v & 32'h1, 32'h1);
    cleanup();
  endtask

  task automatic t_pop_restart();
    logic [31:0] v;
    wr(A_THR, 32'd6); wr(A_CTRL, 32'd1);
    push(8'hA1); push(8'hB2);
    idle(3);
    rd(A_DATA, v); chk("R10 first word", v, 32'h0000_00A1);
    idle(5); chk("R4 irq before T after pop", {31'd0, irq}, 32'd0);
    idle(1); chk("R4 irq at T after pop", {31'd0, irq}, 32'd1);
    cleanup();
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(A_THR, 32'd3); wr(A_CTRL, 32'd1);
    idle(20); chk("R5 empty no timeout", {31'd0, irq}, 32'd0);
    push(8'h11); rd(A_DATA, v);
    idle(20); chk("R5 emptied no timeout", {31'd0, irq}, 32'd0);
    push(8'h22);
    idle(2); chk("R5 counts from zero", {31'd0, irq}, 32'd0);
    idle(1); chk("R5 timeout after refill", {31'd0, irq}, 32'd1);
    cleanup();
  endtask

  task automatic t_sticky_sat();
    logic [31:0] v;
    wr(A_THR, 32'd4); wr(A_CTRL, 32'd1);
    push(8'h33);
    idle(3);
    wr(A_STAT, 32'h1);   // registers on the same edge as the timeout
    chk("R9 clear on hit edge irq", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); chk("R9 clear on hit edge status", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R9 clear by write one", v, 32'h0);
    idle(30);
    rd(A_STAT, v); chk("R6 no retrigger while saturated", v, 32'h0);
    chk("R6 irq stays low", {31'd0, irq}, 32'd0);
    cleanup();
  endtask

  task automatic t_zero_thr();
    logic [31:0] v;
    wr(A_THR, 32'd0); wr(A_CTRL, 32'd1);
    push(8'h44);
    idle(100);
    rd(A_STAT, v); chk("R7 disabled flag", v & 32'h1, 32'h0);
    wr(A_THR, 32'd5);
    idle(4); chk("R7 enable counts from zero", {31'd0, irq}, 32'd0);
    idle(1); chk("R7 timeout after enable", {31'd0, irq}, 32'd1);
    cleanup();
  endtask

  task automatic t_irq_enable();
    logic [31:0] v;
    wr(A_THR, 32'd2); wr(A_CTRL, 32'd0);
    push(8'h55);
    idle(5); chk("R8 masked irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); chk("R8 flag while masked", v & 32'h1, 32'h1);
    wr(A_CTRL, 32'd1); chk("R8 irq on enable", {31'd0, irq}, 32'd1);
    rd(A_CTRL, v); chk("R8 control readback", v, 32'd1);
    wr(A_CTRL, 32'd0); chk("R8 irq on disable", {31'd0, irq}, 32'd0);
    cleanup();
  endtask

  task automatic t_fifo();
    logic [31:0] v;
    wr(A_THR, 32'd0);
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    rd(A_STAT, v); chk("R10 full status", v, 32'h8);
    push(8'hEE);
    rd(A_STAT, v); chk("R11 overrun on full push", v, 32'hA);
    for (int i = 0; i < 8; i++) begin
      rd(A_DATA, v); chk("R10 order", v, 32'h10 + 32'(i));
    end
    rd(A_DATA, v); chk("R12 empty read value", v, 32'h0);
    rd(A_STAT, v); chk("R12 still empty", v, 32'h6);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R11 overrun cleared", v, 32'h4);
    push(8'h77);
    rd(A_DATA, v); chk("R12 fifo intact after empty read", v, 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_thr_reg();
    t_push_timing();
    t_pop_restart();
    t_freeze();
    t_sticky_sat();
    t_zero_thr();
    t_irq_enable();
    t_fifo();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule